// File: doc/BRIEF.md
# Programmable Memory-Window Region Decoder

This block sits on the physical address path and decides whether a 32-bit memory address falls inside a 16 MB window of on-chip resources. If it does, the block picks which of three regions the address belongs to and passes that region a window-relative offset. The three regions are graphics memory, scratchpad/PCI space and control registers.

An 8-bit configuration register sets the window position and the scratchpad size. Software reaches this register through an indexed I/O pair: it first writes an index, then reads or writes a data port. The register must be reachable over I/O because the memory window itself is disabled until the register is programmed.

The decode outputs are combinational from the current register value. A register write takes effect on the clock edge that samples it.

Top module: `mem_window_decoder`

## Requirements
- R1: After reset the configuration register reads 00h through the data port, no region select is active, the scratchpad flags are low, and `gfx_instr_en` is low.
- R2: A data write while the index holds `CFG_INDEX` (B8h by default) stores bits [3:0] of the write data. Reading the data port with that index returns the stored value, and bits [7:4] always read as zero.
- R3: A data read with any other index returns zero. A data write with any other index leaves the configuration register unchanged.
- R4: Register bits [1:0] are the base code. Code 0 disables the window, so no region is selected. Codes 1, 2 and 3 select the window when address bits [31:30] equal the code and address bits [29:24] are all zero. `region_sel` is never more than one-hot.
- R5: A window address with bit 23 = 1 selects graphics memory (`region_sel` = 3'b001), and `offset` equals address bits [23:0].
- R6: A window address with bit 23 = 0 is in control space. Bit 15 = 1 selects control registers (3'b100) and bit 15 = 0 selects scratchpad/PCI (3'b010). `offset` is address bits [14:0], zero-extended. Address bits [22:16] have no effect on the decode. When no region is selected, `offset` is zero.
- R7: Register bits [3:2] set the scratchpad size: 0 gives 0 bytes, 1 gives 2048, 2 gives 3072 and 3 gives 4096. A scratchpad/PCI access raises `spad_hit` when its offset is below the size and raises `spad_miss` otherwise. Both flags are low outside that region.
- R8: `gfx_instr_en` is high exactly when the scratchpad size field is non-zero.
- R9: A configuration write changes the decode only from the clock edge that samples the write. In the cycle the write is presented, the decode still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_idx_we | input | 1 | Write `io_wdata` into the index register |
| io_dat_we | input | 1 | Write `io_wdata` to the indexed register |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Data port read value for the current index |
| mem_addr | input | 32 | Physical memory address to decode |
| region_sel | output | 3 | One-hot region select: bit0 graphics, bit1 scratchpad/PCI, bit2 control registers |
| offset | output | 24 | Window-relative offset |
| spad_hit | output | 1 | Scratchpad access inside the configured size |
| spad_miss | output | 1 | Scratchpad/PCI access at or above the configured size |
| gfx_instr_en | output | 1 | Graphics-instruction enable |

## Verification
The bench builds the decoder with its default index of B8h. That default puts all four base codes and all four scratchpad sizes within reach of a single index.

A directed sweep programs each of the sixteen base and size combinations. For each one it drives addresses clustered on the region boundaries: bits [29:24] set or clear, bits 23 and 15 toggled, bits [22:16] filled with noise, and low offsets placed just around 2048, 3072 and 4096. A random phase follows. It interleaves writes through foreign indices with reads and back-to-back register updates, which exercises the one-edge update timing.

// File: rtl/mem_window_decoder.sv
module mem_window_decoder #(
  parameter logic [7:0] CFG_INDEX = 8'hB8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_idx_we,
  input  logic        io_dat_we,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic [31:0] mem_addr,
  output logic [2:0]  region_sel,
  output logic [23:0] offset,
  output logic        spad_hit,
  output logic        spad_miss,
  output logic        gfx_instr_en
);
  localparam logic [7:0] CFG_MASK = 8'h0F;

  logic [7:0]  idx_q, cfg_q;
  logic [1:0]  base_code, spad_code;
  logic        in_window, cfg_sel;
  logic [14:0] ctl_off, spad_limit;

  assign cfg_sel = (idx_q == CFG_INDEX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      cfg_q <= '0;
    end else begin
      if (io_idx_we) idx_q <= io_wdata;
      if (io_dat_we && cfg_sel) cfg_q <= io_wdata & CFG_MASK;
    end
  end

  assign io_rdata  = cfg_sel ? cfg_q : 8'h00;
  assign base_code = cfg_q[1:0];
  assign spad_code = cfg_q[3:2];

  assign in_window = (base_code != 2'b00) && (mem_addr[31:30] == base_code)
                     && (mem_addr[29:24] == 6'd0);

  assign region_sel[0] = in_window &&  mem_addr[23];
  assign region_sel[1] = in_window && !mem_addr[23] && !mem_addr[15];
  assign region_sel[2] = in_window && !mem_addr[23] &&  mem_addr[15];

  assign ctl_off = mem_addr[14:0];

  always_comb begin
    offset = '0;
    if (region_sel[0])                      offset = mem_addr[23:0];
    else if (region_sel[1] || region_sel[2]) offset = {9'd0, ctl_off};
  end

  always_comb begin
    case (spad_code)
      2'd1:    spad_limit = 15'd2048;
      2'd2:    spad_limit = 15'd3072;
      2'd3:    spad_limit = 15'd4096;
      default: spad_limit = 15'd0;
    endcase
  end

  assign spad_hit     = region_sel[1] && (ctl_off < spad_limit);
  assign spad_miss    = region_sel[1] && (ctl_off >= spad_limit);
  assign gfx_instr_en = (spad_code != 2'b00);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[7:4] == 4'h0);

  // R4
  onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(region_sel));

  // R4
  disabled_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[1:0] == 2'b00) |-> (region_sel == 3'b000));

  // R7
  spad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spad_hit || spad_miss) |-> (region_sel == 3'b010 && !(spad_hit && spad_miss)));

  // R8
  spad_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spad_hit |-> gfx_instr_en);

  // R9
  cfg_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(io_dat_we) && $past(idx_q) == CFG_INDEX)
      |-> (cfg_q == {4'h0, $past(io_wdata[3:0])}));

  // R3
  foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(idx_q) != CFG_INDEX) |-> $stable(cfg_q));
endmodule

// File: tb/mem_window_decoder_test.sv
module mem_window_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_idx_we = 1'b0, io_dat_we = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [31:0] mem_addr = '0;
  logic [2:0]  region_sel;
  logic [23:0] offset;
  logic        spad_hit, spad_miss, gfx_instr_en;

  int checks = 0, errors = 0;
  int m_idx = 0, m_cfg = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mem_window_decoder uut (.*);

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare();
    int base, size, sel, off, a23, a15, lo;
    bit hit;
    base = m_cfg & 3;
    case ((m_cfg >> 2) & 3)
      0: size = 0;
      1: size = 2048;
      2: size = 3072;
      default: size = 4096;
    endcase
    hit = (base != 0) && (int'(mem_addr[31:30]) == base) && (mem_addr[29:24] == 0);
    a23 = mem_addr[23];
    a15 = mem_addr[15];
    lo  = mem_addr[14:0];
    sel = 0;
    off = 0;
    if (hit) begin
      if (a23) begin
        sel = 1;
        off = mem_addr[23:0];
      end else begin
        sel = a15 ? 4 : 2;
        off = lo;
      end
    end
    chk("R4/R5/R6 region_sel", region_sel, sel);
    chk("R5/R6 offset", offset, off);
    chk("R7 spad_hit", spad_hit, (sel == 2) && (lo < size));
    chk("R7 spad_miss", spad_miss, (sel == 2) && (lo >= size));
    chk("R8 gfx_instr_en", gfx_instr_en, size != 0);
    chk("R2/R3/R9 io_rdata", io_rdata, (m_idx == 'hB8) ? m_cfg : 0);
  endtask

  task automatic step(bit iw, bit dw, logic [7:0] wd, logic [31:0] a);
    @(negedge clk);
    io_idx_we = iw;
    io_dat_we = dw;
    io_wdata  = wd;
    mem_addr  = a;
    #2 compare();
    @(posedge clk);
    #1;
    if (dw && m_idx == 'hB8) m_cfg = wd & 'h0F;
    if (iw) m_idx = wd;
  endtask

  function automatic logic [31:0] pick_addr(int base);
    logic [31:0] a;
    int lows[8] = '{0, 2047, 2048, 3071, 3072, 4095, 4096, 32767};
    a = $urandom;
    a[31:30] = ($urandom % 4 == 0) ? 2'($urandom) : 2'(base);
    if ($urandom % 4 != 0) a[29:24] = 0;
    if ($urandom % 2 == 0) a[14:0] = 15'(lows[$urandom % 8]);
    return a;
  endfunction

  initial begin
    #1;
    // R1: reset state with the register index selected
    @(posedge clk); @(posedge clk);
    #2;
    chk("R1 region_sel", region_sel, 0);
    chk("R1 spad_hit", spad_hit, 0);
    chk("R1 gfx_instr_en", gfx_instr_en, 0);
    rst_n = 1'b1;
    step(1, 0, 8'hB8, 32'h4000_0000);
    chk("R1 io_rdata", io_rdata, 0);
    for (int b = 0; b < 4; b++)
      for (int s = 0; s < 4; s++) begin
        // R2: reserved bits written as ones must read zero
        step(0, 1, 8'hF0 | 8'(s << 2) | 8'(b), 32'h0);
        for (int k = 0; k < 40; k++) step(0, 0, 8'h00, pick_addr(b));
        // R6: bits 22:16 changed, decode unaffected
        step(0, 0, 8'h00, {2'(b), 6'd0, 1'b0, 7'h7F, 1'b0, 15'd100});
        // R3: write through another index is ignored
        step(1, 0, 8'h12, 32'h0);
        step(0, 1, 8'h00, pick_addr(b));
        step(1, 0, 8'hB8, pick_addr(b));
      end
    for (int k = 0; k < 1500; k++) begin
      int r = $urandom % 16;
      step(r == 0, r == 1 || r == 2, (r == 0) ? (($urandom % 2) ? 8'hB8 : 8'($urandom)) : 8'($urandom),
           pick_addr(int'(m_cfg & 3)));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule